// File: doc/BRIEF.md
# Streaming Pairwise Float Multiplier

This block sits on a 64-bit streaming datapath. Every input beat carries two single-precision floating-point operands. The block multiplies them and returns one 32-bit product for each beat. It collects two consecutive products into one 64-bit output beat, so the output stream carries half as many beats as the input stream.

The multiplier is split into three registered stages: operand decode, significand multiply, then normalise and round. One packing stage follows them. Both stream edges use a valid/ready handshake. When the consumer stalls, the stall travels back through every stage, so no product is dropped and no operand pair is taken that the block cannot hold. Subnormal numbers are not supported. They are treated as zero, and the block raises no exception flags.

Top module: `fmul_pair_stream`

## Requirements
- R1: An input beat is taken on a clock edge where `s_tvalid` and `s_tready` are both high. Its operands are `s_tdata[31:0]` and `s_tdata[63:32]`, and the beat yields exactly one product of the two.
- R2: Each output beat holds two consecutive products. The earlier product is in `m_tdata[31:0]` and the later one is in `m_tdata[63:32]`, and products leave in the order their beats arrived.
- R3: 2N accepted input beats give exactly N output beats. An unpaired last product is held until its partner arrives and is never sent as a half-filled beat.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` stays unchanged.
- R5: Whenever `m_tready` is high or `m_tvalid` is low, `s_tready` is high, so one operand pair per clock is taken while the consumer keeps up.
- R6: Finite results are rounded to nearest, ties to even. For example, 0x3F800001 times 0x3FC00000 gives 0x3FC00002, and 0x3F800003 times 0x3FC00000 gives 0x3FC00004.
- R7: A subnormal operand is treated as zero. A result whose biased exponent after rounding is 0 or below becomes a zero with the product sign.
- R8: A NaN operand, or an infinity multiplied by a zero, gives the quiet NaN 0x7FC00000.
- R9: An infinity times a nonzero finite value, or a result whose biased exponent reaches 255 or more, gives an infinity with the product sign.
- R10: The product sign is the XOR of the two operand signs, including for zero results.
- R11: Synchronous active-low reset empties every stage and any half-filled pair. `m_tvalid` is low in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 64 | Operand pair: [31:0] first operand, [63:32] second operand |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can take an input beat |
| m_tdata | output | 64 | Product pair: [31:0] earlier product, [63:32] later product |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Consumer takes the output beat |

## Verification
A stage that loses its valid bit or takes new data while stalled shows at the ports within three to four cycles. A product then goes missing or repeats, which moves every later product into the wrong half of the output and leaves the output beat count wrong. A packer that forgets or keeps the held half shows on the very next output beat as a swapped or stale low word. A wrong rounding, class or sign decision shows only in the product word for that operand pair. The bench therefore pairs each operand vector with its exact expected word. It also runs the same stream with the consumer always ready and with the consumer stalling.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXPS_W = EXP_W + 3;
    localparam int LANES  = 2;
    localparam int BEAT_W = LANES * FP_W;

    localparam logic signed [EXPS_W-1:0] BIAS_S    = EXPS_W'(127);
    localparam logic signed [EXPS_W-1:0] EXP_TOP_S = EXPS_W'(255);
    localparam logic signed [EXPS_W-1:0] ONE_S     = EXPS_W'(1);
    localparam logic signed [EXPS_W-1:0] ZERO_S    = EXPS_W'(0);
    localparam logic [FP_W-1:0]          QNAN_W    = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef struct packed {
        logic                     sign;
        logic                     spec;
        logic [FP_W-1:0]          spec_word;
        logic signed [EXPS_W-1:0] exp;
        logic [SIG_W-1:0]         sig_a;
        logic [SIG_W-1:0]         sig_b;
    } op_t;

    typedef struct packed {
        logic                     sign;
        logic                     spec;
        logic [FP_W-1:0]          spec_word;
        logic signed [EXPS_W-1:0] exp;
        logic [PROD_W-1:0]        prod;
    } prod_t;

    function automatic fp_class_e classify(input logic [FP_W-1:0] x);
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        e = x[FP_W-2 -: EXP_W];
        f = x[FRAC_W-1:0];
        if (e == '0)
            return CLS_ZERO;
        else if (e == '1)
            return (f == '0) ? CLS_INF : CLS_NAN;
        else
            return CLS_NORM;
    endfunction

    function automatic logic signed [EXPS_W-1:0] exp_of(input logic [FP_W-1:0] x);
        return $signed({3'b000, x[FP_W-2 -: EXP_W]});
    endfunction

    function automatic op_t decode_pair(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
        op_t       o;
        fp_class_e ca;
        fp_class_e cb;
        ca          = classify(a);
        cb          = classify(b);
        o.sign      = a[FP_W-1] ^ b[FP_W-1];
        o.exp       = exp_of(a) + exp_of(b) - BIAS_S;
        o.sig_a     = {1'b1, a[FRAC_W-1:0]};
        o.sig_b     = {1'b1, b[FRAC_W-1:0]};
        o.spec      = 1'b1;
        o.spec_word = {o.sign, {(FP_W-1){1'b0}}};
        if (ca == CLS_NAN || cb == CLS_NAN)
            o.spec_word = QNAN_W;
        else if ((ca == CLS_INF && cb == CLS_ZERO) || (ca == CLS_ZERO && cb == CLS_INF))
            o.spec_word = QNAN_W;
        else if (ca == CLS_INF || cb == CLS_INF)
            o.spec_word = {o.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (ca == CLS_ZERO || cb == CLS_ZERO)
            o.spec_word = {o.sign, {(FP_W-1){1'b0}}};
        else
            o.spec = 1'b0;
        return o;
    endfunction

    function automatic prod_t multiply(input op_t o);
        prod_t p;
        p.sign      = o.sign;
        p.spec      = o.spec;
        p.spec_word = o.spec_word;
        p.exp       = o.exp;
        p.prod      = o.sig_a * o.sig_b;
        return p;
    endfunction

    function automatic logic [FP_W-1:0] round_pack(input prod_t p);
        logic [FRAC_W-1:0]        frac;
        logic [FRAC_W:0]          sum;
        logic                     guard;
        logic                     sticky;
        logic                     up;
        logic signed [EXPS_W-1:0] e;
        if (p.prod[PROD_W-1]) begin
            frac   = p.prod[PROD_W-2 -: FRAC_W];
            guard  = p.prod[PROD_W-2-FRAC_W];
            sticky = |p.prod[PROD_W-3-FRAC_W:0];
            e      = p.exp + ONE_S;
        end else begin
            frac   = p.prod[PROD_W-3 -: FRAC_W];
            guard  = p.prod[PROD_W-3-FRAC_W];
            sticky = |p.prod[PROD_W-4-FRAC_W:0];
            e      = p.exp;
        end
        up  = guard & (sticky | frac[0]);
        sum = {1'b0, frac} + {{FRAC_W{1'b0}}, up};
        if (sum[FRAC_W])
            e = e + ONE_S;
        frac = sum[FRAC_W-1:0];
        if (p.spec)
            return p.spec_word;
        else if (e >= EXP_TOP_S)
            return {p.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (e <= ZERO_S)
            return {p.sign, {(FP_W-1){1'b0}}};
        else
            return {p.sign, e[EXP_W-1:0], frac};
    endfunction

endpackage

// File: rtl/fmul_stage_reg.sv
module fmul_stage_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else if (in_ready)
            vld_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid)
            dat_q <= in_data;
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

endmodule

// File: rtl/fmul_packer.sv
module fmul_packer #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic           in_ready,
    output logic           out_valid,
    output logic [2*W-1:0] out_data,
    input  logic           out_ready
);

    logic           half_q;
    logic [W-1:0]   low_q;
    logic           ov_q;
    logic [2*W-1:0] od_q;
    logic           take;

    assign in_ready = !half_q || !ov_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            ov_q   <= 1'b0;
        end else begin
            if (ov_q && out_ready)
                ov_q <= 1'b0;
            if (take) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    ov_q   <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            if (!half_q)
                low_q <= in_data;
            else
                od_q <= {in_data, low_q};
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;

endmodule

// File: rtl/fmul_pair_stream.sv
module fmul_pair_stream
    import fmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [BEAT_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready
);

    localparam int OP_W = $bits(op_t);
    localparam int PR_W = $bits(prod_t);

    logic [FP_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = s_tdata[g*FP_W +: FP_W];
    end

    op_t             op_in;
    logic            v1, r1_out;
    logic [OP_W-1:0] d1;
    prod_t           pr_in;
    logic            v2, r2_in, r2_out;
    logic [PR_W-1:0] d2;
    logic [FP_W-1:0] res_in;
    logic            v3, r3_in;
    logic [FP_W-1:0] d3;

    assign op_in = decode_pair(lane[0], lane[1]);

    fmul_stage_reg #(.W(OP_W)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s_tvalid), .in_data(op_in), .in_ready(s_tready),
        .out_valid(v1), .out_data(d1), .out_ready(r1_out)
    );

    assign pr_in  = multiply(op_t'(d1));
    assign r1_out = r2_in;

    fmul_stage_reg #(.W(PR_W)) u_mult (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v1), .in_data(pr_in), .in_ready(r2_in),
        .out_valid(v2), .out_data(d2), .out_ready(r2_out)
    );

    assign res_in = round_pack(prod_t'(d2));
    assign r2_out = r3_in;

    logic r3_out;

    fmul_stage_reg #(.W(FP_W)) u_round (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v2), .in_data(res_in), .in_ready(r3_in),
        .out_valid(v3), .out_data(d3), .out_ready(r3_out)
    );

    fmul_packer #(.W(FP_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v3), .in_data(d3), .in_ready(r3_out),
        .out_valid(m_tvalid), .out_data(m_tdata), .out_ready(m_tready)
    );

endmodule

// File: rtl/fmul_pair_stream_chk.sv
module fmul_pair_stream_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic [63:0] m_tdata
);

    logic [32:0] in_cnt;
    logic [32:0] out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (s_tvalid && s_tready)
                in_cnt <= in_cnt + 33'd1;
            if (m_tvalid && m_tready)
                out_cnt <= out_cnt + 33'd1;
        end
    end

    // R4: a stalled output beat holds
    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R5: consumer ready means the input side is open
    assert_ready_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_tready |-> s_tready);

    // R5: with the output empty the input side is open
    assert_empty_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !m_tvalid |-> s_tready);

    // R3: never more output beats than completed pairs
    assert_pair_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({out_cnt[31:0], 1'b0} <= in_cnt));

    // R3: products in flight never exceed the block's storage
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt - {out_cnt[31:0], 1'b0} <= 33'd6));

    // R11: reset empties the output
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !m_tvalid);

endmodule

bind fmul_pair_stream fmul_pair_stream_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .s_tvalid(s_tvalid),
    .s_tready(s_tready),
    .m_tvalid(m_tvalid),
    .m_tready(m_tready),
    .m_tdata(m_tdata)
);

// File: tb/tb_fmul_pair_stream.sv
module tb_fmul_pair_stream;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // each entry: {operand a, operand b, expected product}; beat = {b, a}
    localparam logic [95:0] VEC [NV] = '{
        {32'h40000000, 32'h40400000, 32'h40C00000},  // R1: 2 * 3
        {32'h3FC00000, 32'h3FC00000, 32'h40100000},  // R1: 1.5 * 1.5
        {32'hC0000000, 32'h40400000, 32'hC0C00000},  // R10: -2 * 3
        {32'h3F000000, 32'h3F000000, 32'h3E800000},  // R1: 0.5 * 0.5
        {32'h00000000, 32'hC0400000, 32'h80000000},  // R10: +0 * -3
        {32'h7F800000, 32'h40000000, 32'h7F800000},  // R9: inf * 2
        {32'h7F800000, 32'h00000000, 32'h7FC00000},  // R8: inf * 0
        {32'h7FC00001, 32'h3F800000, 32'h7FC00000},  // R8: NaN * 1
        {32'h7F000000, 32'h40000000, 32'h7F800000},  // R9: exponent overflow
        {32'h00800000, 32'h3F000000, 32'h00000000},  // R7: result underflow
        {32'h80000001, 32'h40000000, 32'h80000000},  // R7: subnormal input, R10 sign
        {32'h3F800001, 32'h3FC00000, 32'h3FC00002},  // R6: tie rounds up to even
        {32'h3F800003, 32'h3FC00000, 32'h3FC00004},  // R6: tie stays even
        {32'h3F800001, 32'h3F7FFFFF, 32'h3F800000}   // R6: below half rounds down
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b0;

    int nchk = 0;
    int nbad = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int ngot = 0;
    int r4_viol = 0;
    int r5_viol = 0;
    logic [63:0] got [0:15];
    logic        prev_stall = 1'b0;
    logic [63:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmul_pair_stream dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // consumer: sets ready at the falling edge, samples 2 time units later
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: m_tready = 1'b1;
                1: m_tready = cyc[0];
                2: m_tready = (cyc % 3 == 0);
                default: m_tready = 1'b0;
            endcase
            cyc++;
            #2;
            if (rst_n) begin
                if (prev_stall && (!m_tvalid || m_tdata !== prev_data))
                    r4_viol++;
                if (m_tvalid && m_tready && ngot < 16) begin
                    got[ngot] = m_tdata;
                    ngot++;
                end
                if (rdy_mode == 0 && !s_tready)
                    r5_viol++;
            end
            prev_stall = rst_n && m_tvalid && !m_tready;
            prev_data  = m_tdata;
        end
    end

    task automatic send(input logic [63:0] beat);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = beat;
        #1;
        while (!s_tready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic wait_beats(input int n);
        for (int k = 0; k < 200; k++) begin
            if (ngot >= n) break;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic run_table(input int mode);
        rdy_mode = mode;
        ngot = 0;
        for (int i = 0; i < NV; i++)
            send({VEC[i][63:32], VEC[i][95:64]});
        idle();
        wait_beats(NV/2);
        check(ngot == NV/2, "R3", "beat count for table", 64'(ngot), 64'(NV/2));
        for (int k = 0; k < NV/2; k++) begin
            check(got[k][31:0] === VEC[2*k][31:0], "R2", "low product",
                  {32'h0, got[k][31:0]}, {32'h0, VEC[2*k][31:0]});
            check(got[k][63:32] === VEC[2*k+1][31:0], "R2", "high product",
                  {32'h0, got[k][63:32]}, {32'h0, VEC[2*k+1][31:0]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        rdy_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state
        check(m_tvalid == 1'b0, "R11", "tvalid after reset", 64'(m_tvalid), 64'd0);
        check(s_tready == 1'b1, "R11", "tready after reset", 64'(s_tready), 64'd1);

        // R1 R2 R6 R7 R8 R9 R10 with an always-ready consumer
        run_table(0);
        // R4 same stream with a stalling consumer
        run_table(2);
        run_table(1);
        check(r4_viol == 0, "R4", "stalled beat changed", 64'(r4_viol), 64'd0);
        check(r5_viol == 0, "R5", "input blocked while consumer ready", 64'(r5_viol), 64'd0);

        // R3: odd leftover is held, then paired
        rdy_mode = 0;
        ngot = 0;
        send({32'h40400000, 32'h40000000});
        send({32'h3FC00000, 32'h3FC00000});
        send({32'h3F000000, 32'h3F000000});
        idle();
        wait_beats(2);
        check(ngot == 1, "R3", "odd leftover not emitted", 64'(ngot), 64'd1);
        check(got[0] === 64'h40100000_40C00000, "R2", "first pair", got[0], 64'h40100000_40C00000);
        send({32'h40400000, 32'hC0000000});
        idle();
        wait_beats(2);
        check(ngot == 2, "R3", "leftover paired", 64'(ngot), 64'd2);
        check(got[1] === 64'hC0C00000_3E800000, "R3", "leftover in low half", got[1], 64'hC0C00000_3E800000);

        // R11: reset drops a full output beat and a held half
        rdy_mode = 3;
        send({32'h40400000, 32'h40000000});
        send({32'h3FC00000, 32'h3FC00000});
        send({32'h3F000000, 32'h3F000000});
        idle();
        repeat (8) @(negedge clk);
        #1;
        check(m_tvalid == 1'b1, "R4", "beat held under stall", 64'(m_tvalid), 64'd1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(m_tvalid == 1'b0, "R11", "tvalid during reset", 64'(m_tvalid), 64'd0);
        rst_n = 1'b1;
        rdy_mode = 0;
        ngot = 0;
        send({32'h3FC00000, 32'h3FC00000});
        idle();
        wait_beats(1);
        check(ngot == 0, "R11", "held half cleared by reset", 64'(ngot), 64'd0);
        send({32'h40400000, 32'h40000000});
        idle();
        wait_beats(1);
        check(ngot == 1, "R11", "beats after reset", 64'(ngot), 64'd1);
        check(got[0] === 64'h40C00000_40100000, "R11", "fresh pair after reset",
              got[0], 64'h40C00000_40100000);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule